// File: doc/BRIEF.md
# Serial Flash Instruction Sequencer

This block drives a serial NOR flash device through instruction sequences that software programs into a small table rather than through fixed opcodes. Each table entry describes one bus phase: the command byte, the address, idle cycles, or a data transfer in either direction. Each entry carries its own bus width of one, two or four data lines, so a single sequence can mix widths, for example a command on one line followed by data on four.

A host first loads the 64-word table through a write port. It then starts a transaction by writing a command word that selects one of sixteen sequences and gives a byte count. The engine asserts chip select, walks the selected sequence slot by slot and drives the serial clock and the pad lines. It moves write data from a byte source and delivers read bytes one per strobe. A busy output covers the whole transaction, and a finished flag rises when the sequence ends.

Top module: `sflash_seq`

## Requirements
- R1: A write on `cmd_we` while idle starts sequence `cmd_wdata[27:24]` with byte count `cmd_wdata[15:0]` and latches `flash_addr`. From the next cycle `busy` is 1 and `cs_n` is 0. Execution begins at table word 4*index with the slot in bits 15:0, then the slot in bits 31:16, then the following word. A command write while busy has no effect.
- R2: A slot is 16 bits: operand in bits 7:0, line-width code in bits 9:8 (0 = one line, 1 = two, 2 = four, 3 = one), instruction code in bits 15:10. The codes are 0 end, 1 command, 2 address, 3 idle, 7 read, 8 write.
- R3: A command slot sends its 8-bit operand MSB first. One line uses pad 0, two lines use pads 1:0 and four lines use pads 3:0, with the higher bits on the higher pad. Four-line mode sends the upper nibble first. `pad_oe` enables exactly the lines in use.
- R4: An address slot sends the latched address MSB first on its lines: all 32 bits when the operand is 0x20, otherwise its low 24 bits.
- R5: An idle slot gives operand-many serial clocks with `pad_oe` at 0. An operand of 0 gives no clocks.
- R6: A write slot sends byte-count bytes MSB first from `tx_data`. `tx_pop` pulses for one cycle each time a byte is taken, so the source then presents the next byte. A byte count of 0 skips the slot.
- R7: A read slot captures min(byte count, operand) bytes MSB first with `pad_oe` at 0. It samples pad 1 on one line, pads 1:0 on two lines and pads 3:0 on four lines. Each byte appears on `rx_data` with a one-cycle `rx_valid` pulse. A result of 0 skips the slot.
- R8: The sequence ends at an end slot, at any code not listed in R2, or after its eighth slot. At the end `cs_n` returns to 1, `busy` to 0, and `done` becomes 1. `done` stays 1 until the next accepted start.
- R9: `sck` is 0 whenever `cs_n` is 1. Each high phase of `sck` lasts one system cycle, so the fastest serial clock is half the system clock. Outputs change only with a falling edge of `sck`. Inputs are captured at the system edge that ends the high phase.
- R10: After reset `cs_n` is 1, and `sck`, `busy`, `done`, `pad_oe`, `tx_pop` and `rx_valid` are 0.
- R11: `tbl_we` writes `tbl_wdata` into table word `tbl_waddr`, and later sequences execute the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_waddr | input | 6 | Table word index |
| tbl_wdata | input | 32 | Table word, two slots |
| cmd_we | input | 1 | Command write strobe (start) |
| cmd_wdata | input | 32 | Sequence index [27:24], byte count [15:0] |
| flash_addr | input | 32 | Flash address latched at start |
| tx_data | input | 8 | Next byte to transmit |
| tx_pop | output | 1 | Transmit byte taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction has finished |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| pad_o | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| pad_i | input | 4 | Pad input values |

## Verification
The bench models the flash device: it records the pad lines at every rising serial clock and returns a known nibble pattern indexed by beat number. It compares the full beat stream and the received bytes against values it computes from its own copy of the table. The sweeps cover every line width for commands, addresses and data, both address lengths, and the read limit where the operand is smaller than the count. They also cover zero-length idle and data slots, a sequence of eight slots with no end code (a design that overran would clock the next sequence's command), an unlisted code that must stop the run, and the last sequence index. A start issued while busy would restart the run or lengthen the stream if it were not ignored. A wrong nibble order in four-line mode or a sample taken one beat off would show up as byte mismatches.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_we,
  input  logic [5:0]  tbl_waddr,
  input  logic [31:0] tbl_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic [31:0] flash_addr,
  input  logic [7:0]  tx_data,
  output logic        tx_pop,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        busy,
  output logic        done,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  pad_o,
  output logic [3:0]  pad_oe,
  input  logic [3:0]  pad_i
);
  localparam logic [5:0] OP_END = 6'd0, OP_CMD = 6'd1, OP_ADR = 6'd2,
                         OP_IDLE = 6'd3, OP_RD = 6'd7, OP_WR = 6'd8;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_LOW, S_HIGH} st_t;

  logic [31:0]      tbl [64];
  st_t              st;
  logic [6:0]       pc;
  logic [LEN_W-1:0] len_q, left;
  logic [31:0]      addr_q, sr, sr_next;
  logic [7:0]       rsr, rx_next, bcnt;
  logic [5:0]       code_q;
  logic [1:0]       lg_q;

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_waddr] <= tbl_wdata;

  wire [31:0] word = tbl[pc[6:1]];
  wire [15:0] ins  = pc[0] ? word[31:16] : word[15:0];
  wire [5:0]  ic   = ins[15:10];
  wire [1:0]  lg   = (ins[9:8] == 2'd3) ? 2'd0 : ins[9:8];
  wire [7:0]  opr  = ins[7:0];
  wire [LEN_W-1:0] opr_x = {{(LEN_W-8){1'b0}}, opr};
  wire [LEN_W-1:0] rd_n  = (opr_x < len_q) ? opr_x : len_q;
  wire known = ic inside {OP_CMD, OP_ADR, OP_IDLE, OP_RD, OP_WR};
  wire skip  = (ic == OP_IDLE && opr == 8'd0) || (ic == OP_WR && len_q == '0) ||
               (ic == OP_RD && rd_n == '0);
  wire last_slot = (pc[2:0] == 3'd7);
  wire is_data   = (code_q == OP_RD) || (code_q == OP_WR);
  wire [7:0] bpb = 8'd8 >> lg_q;
  wire drive = (st == S_LOW || st == S_HIGH) &&
               (code_q == OP_CMD || code_q == OP_ADR || code_q == OP_WR);
  wire unused_bits = ^{cmd_wdata[31:28], cmd_wdata[23:LEN_W]};

  always_comb begin
    case (lg_q)
      2'd0:    begin sr_next = {sr[30:0], 1'b0};  rx_next = {rsr[6:0], pad_i[1]};
                     pad_o = drive ? {3'b0, sr[31]} : 4'h0;    pad_oe = drive ? 4'h1 : 4'h0; end
      2'd1:    begin sr_next = {sr[29:0], 2'b0};  rx_next = {rsr[5:0], pad_i[1:0]};
                     pad_o = drive ? {2'b0, sr[31:30]} : 4'h0; pad_oe = drive ? 4'h3 : 4'h0; end
      default: begin sr_next = {sr[27:0], 4'b0};  rx_next = {rsr[3:0], pad_i};
                     pad_o = drive ? sr[31:28] : 4'h0;         pad_oe = drive ? 4'hF : 4'h0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; done <= 1'b0; cs_n <= 1'b1; sck <= 1'b0;
      tx_pop <= 1'b0; rx_valid <= 1'b0; rx_data <= '0; pc <= '0; len_q <= '0;
      addr_q <= '0; sr <= '0; rsr <= '0; bcnt <= '0; left <= '0; code_q <= '0; lg_q <= '0;
    end else begin
      tx_pop <= 1'b0;
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_we) begin
          busy <= 1'b1; done <= 1'b0; cs_n <= 1'b0;
          pc <= {cmd_wdata[27:24], 3'b000};
          len_q <= cmd_wdata[LEN_W-1:0];
          addr_q <= flash_addr;
          st <= S_LOAD;
        end
        S_LOAD: begin
          code_q <= ic;
          lg_q <= lg;
          if (!known || (skip && last_slot)) begin
            busy <= 1'b0; done <= 1'b1; cs_n <= 1'b1; st <= S_IDLE;
          end else if (skip) begin
            pc <= pc + 7'd1;
          end else begin
            st <= S_LOW;
            bcnt <= 8'd8 >> lg;
            left <= (ic == OP_RD) ? rd_n : len_q;
            case (ic)
              OP_CMD:  sr <= {opr, 24'h0};
              OP_ADR:  begin
                sr <= (opr == 8'h20) ? addr_q : {addr_q[23:0], 8'h0};
                bcnt <= ((opr == 8'h20) ? 8'd32 : 8'd24) >> lg;
              end
              OP_IDLE: bcnt <= opr;
              OP_WR:   begin sr <= {tx_data, 24'h0}; tx_pop <= 1'b1; end
              default: ;
            endcase
          end
        end
        S_LOW: begin
          sck <= 1'b1;
          st <= S_HIGH;
        end
        default: begin
          sck <= 1'b0;
          sr <= sr_next;
          rsr <= rx_next;
          bcnt <= bcnt - 8'd1;
          st <= S_LOW;
          if (bcnt == 8'd1) begin
            if (code_q == OP_RD) begin rx_data <= rx_next; rx_valid <= 1'b1; end
            if (is_data && left != {{(LEN_W-1){1'b0}}, 1'b1}) begin
              left <= left - 1'b1;
              bcnt <= bpb;
              if (code_q == OP_WR) begin sr <= {tx_data, 24'h0}; tx_pop <= 1'b1; end
            end else if (last_slot) begin
              busy <= 1'b0; done <= 1'b1; cs_n <= 1'b1; st <= S_IDLE;
            end else begin
              pc <= pc + 7'd1;
              st <= S_LOAD;
            end
          end
        end
      endcase
    end
  end

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  p_sck_short_r9: assert property (@(posedge clk) disable iff (!rst_n) sck |=> !sck);
  p_pad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(pad_o));
  p_end_flags_r8: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done && cs_n));
  p_rx_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> ($past(pad_oe) == 4'h0));
  p_pop_in_seq_r6: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !cs_n);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n) (!busy && cmd_we) |=> (busy && !cs_n));
endmodule

// File: tb/test_sflash_seq.sv
module test_sflash_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0, cmd_we = 1'b0;
  logic [5:0] tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0, cmd_wdata = '0, flash_addr = '0;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_pop, rx_valid, busy, done, sck, cs_n;
  logic [3:0] pad_o, pad_oe, pad_i = '0;

  sflash_seq i_sflash_seq (.clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .flash_addr(flash_addr),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .done(done), .sck(sck), .cs_n(cs_n), .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] shw [64];
  logic [3:0] rec_o [512], rec_oe [512], exp_o [512], exp_oe [512];
  logic [7:0] rx_got [64], exp_rx [64];
  int k = 0, nrx = 0, ntx = 0, tviol = 0, exp_n = 0, exp_rxn = 0, exp_tx = 0;
  logic last_sck = 1'b0;
  logic [3:0] hold_o = '0;

  function automatic logic [3:0] fpat(int n); return 4'(n * 7 + 5); endfunction
  function automatic logic [7:0] txpat(int n); return 8'(32'hA5 ^ (n * 61)); endfunction
  function automatic logic [15:0] ins(int code, int pad, int op);
    return {6'(code), 2'(pad), 8'(op)};
  endfunction

  // flash device model
  always @(negedge cs_n) begin k = 0; pad_i = fpat(0); end
  always @(posedge sck) begin
    if (k < 512) begin rec_o[k] = pad_o; rec_oe[k] = pad_oe; end
    hold_o = pad_o;
    k++;
  end
  always @(negedge sck) pad_i = fpat(k);
  always @(negedge clk) begin
    if (sck && last_sck) tviol++;
    if (sck && pad_o !== hold_o) tviol++;
    if (sck && cs_n) tviol++;
    last_sck = sck;
    if (rx_valid) begin if (nrx < 64) rx_got[nrx] = rx_data; nrx++; end
    if (tx_pop) begin ntx++; tx_data = txpat(ntx); end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, expv); end
  endtask

  task automatic push_beat(input logic [3:0] o, input logic [3:0] oe);
    exp_o[exp_n] = o; exp_oe[exp_n] = oe; exp_n++;
  endtask

  task automatic push_val(input logic [31:0] v, input int nbits, input int lgv);
    logic [31:0] t;
    t = v;
    for (int j = 0; j < (nbits >> lgv); j++) begin
      if (lgv == 0) push_beat({3'b0, t[31]}, 4'h1);
      else if (lgv == 1) push_beat({2'b0, t[31:30]}, 4'h3);
      else push_beat(t[31:28], 4'hF);
      t = t << (1 << lgv);
    end
  endtask

  task automatic build(input int idx, input int len, input logic [31:0] adr);
    bit fin;
    fin = 0; exp_n = 0; exp_rxn = 0; exp_tx = 0;
    for (int s = 0; s < 8 && !fin; s++) begin
      logic [31:0] wv;
      logic [15:0] iw;
      int code, lgv, w, op, n;
      logic [7:0] bv;
      logic [3:0] p;
      wv = shw[(idx * 8 + s) / 2];
      iw = (s % 2 == 1) ? wv[31:16] : wv[15:0];
      code = int'(iw[15:10]);
      lgv = (iw[9:8] == 2'd3) ? 0 : int'(iw[9:8]);
      w = 1 << lgv;
      op = int'(iw[7:0]);
      case (code)
        1: push_val({iw[7:0], 24'h0}, 8, lgv);
        2: if (op == 32) push_val(adr, 32, lgv); else push_val({adr[23:0], 8'h0}, 24, lgv);
        3: for (int j = 0; j < op; j++) push_beat(4'h0, 4'h0);
        8: begin
          for (int b = 0; b < len; b++) push_val({txpat(b), 24'h0}, 8, lgv);
          exp_tx = len;
        end
        7: begin
          n = (len < op) ? len : op;
          for (int b = 0; b < n; b++) begin
            bv = 8'h0;
            for (int j = 0; j < 8 / w; j++) begin
              p = fpat(exp_n);
              if (lgv == 0) bv = {bv[6:0], p[1]};
              else if (lgv == 1) bv = {bv[5:0], p[1:0]};
              else bv = {bv[3:0], p};
              push_beat(4'h0, 4'h0);
            end
            exp_rx[b] = bv;
          end
          exp_rxn = n;
        end
        default: fin = 1;
      endcase
    end
  endtask

  task automatic put(input int a, input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 6'(a); tbl_wdata = {hi, lo}; shw[a] = {hi, lo};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run(input int idx, input int len, input logic [31:0] adr,
                     input string tag, input bit retrig);
    int cyc, mm, fa, fe;
    build(idx, len, adr);
    @(negedge clk);
    flash_addr = adr; ntx = 0; nrx = 0; tviol = 0; tx_data = txpat(0);
    cmd_we = 1'b1; cmd_wdata = {4'h0, 4'(idx), 8'h0, 16'(len)};
    @(negedge clk);
    cmd_we = 1'b0;
    chk(busy && !cs_n, $sformatf("R1 start seq%0d busy/cs_n", idx), {busy, cs_n}, 2'b10);
    chk(!done, $sformatf("R8 done cleared by start seq%0d", idx), done, 0);
    if (retrig) begin
      repeat (20) @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = {4'h0, 4'd1, 8'h0, 16'd9}; flash_addr = 32'h0;
      @(negedge clk);
      cmd_we = 1'b0;
    end
    cyc = 0;
    while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(!busy && cs_n && done, $sformatf("R8 end flags seq%0d", idx), {busy, cs_n, done}, 3'b011);
    chk(k == exp_n, $sformatf("%s beat count seq%0d", tag, idx), k, exp_n);
    mm = 0; fa = 0; fe = 0;
    for (int j = 0; j < exp_n && j < k && j < 512; j++)
      if (rec_o[j] !== exp_o[j] || rec_oe[j] !== exp_oe[j]) begin
        if (mm == 0) begin fa = {rec_oe[j], rec_o[j]}; fe = {exp_oe[j], exp_o[j]}; end
        mm++;
      end
    chk(mm == 0, $sformatf("%s pad stream seq%0d", tag, idx), fa, fe);
    chk(nrx == exp_rxn, $sformatf("R7 rx count seq%0d", idx), nrx, exp_rxn);
    mm = 0; fa = 0; fe = 0;
    for (int j = 0; j < exp_rxn && j < nrx; j++)
      if (rx_got[j] !== exp_rx[j]) begin
        if (mm == 0) begin fa = rx_got[j]; fe = exp_rx[j]; end
        mm++;
      end
    chk(mm == 0, $sformatf("R7 rx bytes seq%0d", idx), fa, fe);
    chk(ntx == exp_tx, $sformatf("R6 tx pops seq%0d", idx), ntx, exp_tx);
    chk(tviol == 0, $sformatf("R9 clock/launch timing seq%0d", idx), tviol, 0);
    if (retrig) begin
      repeat (5) @(negedge clk);
      chk(!busy && cs_n, "R1 start while busy ignored", {busy, cs_n}, 2'b01);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy && !done && pad_oe == 4'h0 && !tx_pop && !rx_valid,
        "R10 reset state", {cs_n, sck, busy, done, pad_oe, tx_pop, rx_valid}, 10'h200);
    rst_n = 1'b1;
    for (int a = 0; a < 64; a++) put(a, 16'h0, 16'h0);
    put(0,  ins(1, 0, 8'h6B), ins(2, 0, 8'h18));
    put(1,  ins(3, 0, 8),     ins(7, 2, 8'h80));
    put(4,  ins(1, 0, 8'h06), ins(0, 0, 0));
    put(8,  ins(1, 0, 8'h02), ins(2, 0, 8'h20));
    put(9,  ins(8, 0, 0),     ins(0, 0, 0));
    put(12, ins(1, 2, 8'hEB), ins(2, 2, 8'h18));
    put(13, ins(3, 2, 4),     ins(7, 1, 2));
    put(16, ins(1, 1, 8'h3B), ins(2, 1, 8'h20));
    put(17, ins(8, 2, 0),     ins(7, 0, 1));
    for (int a = 0; a < 4; a++) put(20 + a, ins(1, 0, 8'h11 + 2 * a), ins(1, 0, 8'h12 + 2 * a));
    put(24, ins(1, 0, 8'hAA), ins(0, 0, 0));
    put(28, ins(3, 0, 0),     ins(1, 0, 8'h9F));
    put(29, ins(7, 0, 3),     ins(0, 0, 0));
    put(32, ins(1, 0, 8'h05), ins(4, 0, 0));
    put(33, ins(1, 0, 8'h77), ins(0, 0, 0));
    put(36, ins(8, 0, 0),     ins(7, 0, 5));
    put(37, ins(1, 0, 8'hC3), ins(0, 0, 0));
    put(60, ins(1, 3, 8'hC7), ins(0, 0, 0));

    run(1, 0, 32'h0, "R3 single-line command", 1'b0);
    run(0, 5, 32'h00C3_5A17, "R2 R4 R5 R11 quad read seq", 1'b0);
    run(0, 4, 32'h0012_3456, "R1 R4 retrigger", 1'b1);
    run(2, 3, 32'h89AB_CDEF, "R4 R6 32-bit address write", 1'b0);
    run(3, 6, 32'h00FE_DCBA, "R3 R5 R7 quad command limited read", 1'b0);
    run(4, 2, 32'h1357_9BDF, "R3 R6 R7 dual/quad mixed", 1'b0);
    run(5, 0, 32'h0, "R8 eight slots without end", 1'b0);
    run(7, 3, 32'h0, "R5 R7 zero idle", 1'b0);
    run(8, 1, 32'h0, "R8 unlisted code ends", 1'b0);
    run(9, 0, 32'h0, "R6 R7 zero count skip", 1'b0);
    run(15, 0, 32'h0, "R1 R2 last index pad code 3", 1'b0);
    put(4, ins(1, 2, 8'h5A), ins(0, 0, 0));
    run(1, 0, 32'h0, "R11 table rewrite", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule